// File: doc/BRIEF.md
# Light-Load Standby Event Manager

This block sits beside the PWM stage of a current-mode switching controller and decides when the converter drops into its low-power standby condition and when it comes back out. It watches two comparator flags on the feedback node. One says the load demand has fallen below the pulse-skipping level, which is a quarter of full peak current. The other says demand has climbed past a higher exit level. From these flags it drives two outputs. One is a pulse-blanking request to the PWM stage. The other is the enable of an auxiliary supply switch that powers a downstream power-factor correction stage.

The policy is deliberately lopsided. Entering standby, which opens the auxiliary switch, needs the light-load flag to stay high without a break for a confirmation window. The window is counted in clock-enable ticks, so a 1 ms tick and the default setting give 125 ms. Leaving standby happens as soon as the exit flag is seen. Feedback ripple that moves only around the skip level cannot bring the auxiliary supply back.

The auxiliary switch stays open until the startup sequence is reported complete. A fault or latch-off indication forces it open, and the block then goes back to waiting for startup completion.

Top module: `standby_event_mgr`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `auxEnable` and `skipReq` are both 0.
- R2: `skipReq` equals the value `fbBelowSkip` had on the previous rising clock edge.
- R3: After reset, `auxEnable` stays 0 for as long as `startupDone` is 0. On the first edge that samples `startupDone` high with no fault, `auxEnable` becomes 1.
- R4: With the auxiliary switch closed, `fbBelowSkip` held high continuously opens the switch only on the edge that samples the WINDOW_TICKS-th `tick` after `fbBelowSkip` was first seen. Until that edge, `auxEnable` stays 1.
- R5: If `fbBelowSkip` drops for even one sampled cycle during the confirmation window, the tick count is discarded. A later light-load period again needs WINDOW_TICKS ticks.
- R6: In standby, a sampled `fbAboveExit` high closes the auxiliary switch on that same edge, so `auxEnable` is 1 one cycle later. No tick is needed.
- R7: In standby, `fbBelowSkip` falling while `fbAboveExit` stays 0 leaves `auxEnable` at 0.
- R8: A sampled `faultLatched` high makes `auxEnable` 0 after that edge, whatever the state. Once the fault clears, `auxEnable` returns to 1 only when `startupDone` is sampled high.
- R9: Clock cycles without `tick` do not advance the confirmation window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable that advances the confirmation timer |
| fbBelowSkip | input | 1 | Feedback is below the skip (light-load) level |
| fbAboveExit | input | 1 | Feedback is above the standby exit level |
| startupDone | input | 1 | Startup sequence judged normal |
| faultLatched | input | 1 | Fault or latch-off condition present |
| skipReq | output | 1 | Pulse-blanking request to the PWM stage |
| auxEnable | output | 1 | Auxiliary supply switch enable (1 = closed) |

## Verification
The hardest condition to reach from the ports is the last tick of an unbroken confirmation window, together with the same situation after the window was interrupted partway. The bench shortens the window through the parameter. It delivers ticks one at a time, checking that the switch is still closed after the second-to-last tick and open after the last one. It then repeats the window after a one-cycle drop of the light-load flag, and once more with long tick-free gaps, to show that only an uninterrupted count of ticks leads into standby.

// File: rtl/standby_pkg.sv
package standby_pkg;

  typedef enum logic [1:0] {
    ST_STARTUP = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_STANDBY = 2'd3
  } standbyState_e;

  typedef struct packed {
    logic timerClear;
    logic timerStep;
  } timerCtl_t;

endpackage

// File: rtl/standby_timer_dp.sv
module standby_timer_dp
  import standby_pkg::*;
#(
  parameter int WINDOW_TICKS = 125
) (
  input  logic      clk,
  input  logic      rst,
  input  timerCtl_t ctl,
  input  logic      fbBelowSkip,
  output logic      timerDone,
  output logic      skipReq
);

  localparam int CNT_W = $clog2(WINDOW_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

  logic [CNT_W-1:0] cntQ;
  logic             skipQ;

  always_ff @(posedge clk) begin
    if (rst || ctl.timerClear) begin
      cntQ <= '0;
    end else if (ctl.timerStep) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      skipQ <= 1'b0;
    end else begin
      skipQ <= fbBelowSkip;
    end
  end

  assign timerDone = (cntQ == LAST);
  assign skipReq   = skipQ;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cntQ <= LAST);

  // R2
  skip_follow_chk: assert property (@(posedge clk) disable iff (rst)
    fbBelowSkip |=> skipReq);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.timerClear |=> (cntQ == '0));

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      fbBelowSkip,
  input  logic      fbAboveExit,
  input  logic      startupDone,
  input  logic      faultLatched,
  input  logic      timerDone,
  output timerCtl_t ctl,
  output logic      auxEnable
);

  standbyState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (faultLatched) begin
      stateD = ST_STARTUP;
    end else begin
      unique case (stateQ)
        ST_STARTUP: if (startupDone) stateD = ST_ACTIVE;
        ST_ACTIVE:  if (fbBelowSkip) stateD = ST_CONFIRM;
        ST_CONFIRM: begin
          if (!fbBelowSkip)           stateD = ST_ACTIVE;
          else if (tick && timerDone) stateD = ST_STANDBY;
        end
        ST_STANDBY: if (fbAboveExit) stateD = ST_ACTIVE;
        default:                     stateD = ST_STARTUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_STARTUP;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    ctl.timerClear = (stateQ != ST_CONFIRM);
    ctl.timerStep  = (stateQ == ST_CONFIRM) && tick && fbBelowSkip && !timerDone;
  end

  assign auxEnable = (stateQ == ST_ACTIVE) || (stateQ == ST_CONFIRM);

  // R8
  fault_open_chk: assert property (@(posedge clk) disable iff (rst)
    faultLatched |=> !auxEnable);

  // R6
  exit_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_STANDBY && fbAboveExit && !faultLatched) |=> auxEnable);

  // R3
  startup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_STARTUP && !startupDone) |=> !auxEnable);

  // R4
  entry_confirmed_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(auxEnable) && !$past(faultLatched)) |-> $past(timerDone && tick));

  // R7
  ripple_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_STANDBY && !fbAboveExit) |=> !auxEnable);

endmodule

// File: rtl/standby_event_mgr.sv
module standby_event_mgr
  import standby_pkg::*;
#(
  parameter int WINDOW_TICKS = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fbBelowSkip,
  input  logic fbAboveExit,
  input  logic startupDone,
  input  logic faultLatched,
  output logic skipReq,
  output logic auxEnable
);

  timerCtl_t timerCtl;
  logic      timerDone;

  standby_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .fbBelowSkip  (fbBelowSkip),
    .fbAboveExit  (fbAboveExit),
    .startupDone  (startupDone),
    .faultLatched (faultLatched),
    .timerDone    (timerDone),
    .ctl          (timerCtl),
    .auxEnable    (auxEnable)
  );

  standby_timer_dp #(.WINDOW_TICKS(WINDOW_TICKS)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (timerCtl),
    .fbBelowSkip (fbBelowSkip),
    .timerDone   (timerDone),
    .skipReq     (skipReq)
  );

endmodule

// File: tb/standby_event_mgr_tb.sv
module standby_event_mgr_tb;

  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic fbBelowSkip = 1'b0;
  logic fbAboveExit = 1'b0;
  logic startupDone = 1'b0;
  logic faultLatched = 1'b0;
  logic skipReq, auxEnable;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  standby_event_mgr #(.WINDOW_TICKS(WIN)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .fbBelowSkip(fbBelowSkip),
    .fbAboveExit(fbAboveExit), .startupDone(startupDone),
    .faultLatched(faultLatched), .skipReq(skipReq), .auxEnable(auxEnable)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic giveTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; tick = 0; fbBelowSkip = 0; fbAboveExit = 0;
    startupDone = 0; faultLatched = 0;
    cyc(3);
    check("R1 aux in reset", auxEnable, 1'b0);
    check("R1 skip in reset", skipReq, 1'b0);
    rst = 1'b0;
    cyc(1);
    check("R1 aux after release", auxEnable, 1'b0);
  endtask

  task automatic testStartup();
    doReset();
    cyc(20);
    check("R3 aux held open before startup", auxEnable, 1'b0);
    startupDone = 1'b1;
    cyc(1);
    check("R3 aux closes after startup", auxEnable, 1'b1);
  endtask

  task automatic testEntry();
    fbBelowSkip = 1'b1;
    cyc(1);
    check("R2 skip follows input", skipReq, 1'b1);
    giveTicks(WIN - 1);
    check("R4 aux closed before last tick", auxEnable, 1'b1);
    giveTicks(1);
    check("R4 aux opens on last tick", auxEnable, 1'b0);
  endtask

  task automatic testRipple();
    fbBelowSkip = 1'b0;
    cyc(1);
    check("R2 skip drops", skipReq, 1'b0);
    cyc(5);
    check("R7 ripple keeps aux open", auxEnable, 1'b0);
    fbBelowSkip = 1'b1;
    cyc(2);
    check("R7 still standby", auxEnable, 1'b0);
  endtask

  task automatic testExit();
    fbBelowSkip = 1'b0;
    fbAboveExit = 1'b1;
    cyc(1);
    check("R6 immediate exit", auxEnable, 1'b1);
    check("R2 skip stops on exit", skipReq, 1'b0);
    fbAboveExit = 1'b0;
    cyc(1);
  endtask

  task automatic testRestart();
    fbBelowSkip = 1'b1;
    cyc(1);
    giveTicks(WIN - 3);
    fbBelowSkip = 1'b0;
    cyc(1);
    fbBelowSkip = 1'b1;
    cyc(1);
    giveTicks(WIN - 1);
    check("R5 window restarted, aux closed", auxEnable, 1'b1);
    giveTicks(1);
    check("R5 full new window opens aux", auxEnable, 1'b0);
    fbBelowSkip = 1'b0; fbAboveExit = 1'b1;
    cyc(1);
    fbAboveExit = 1'b0;
    check("R6 exit after restart test", auxEnable, 1'b1);
  endtask

  task automatic testNoTick();
    fbBelowSkip = 1'b1;
    cyc(1);
    giveTicks(WIN - 1);
    cyc(60);
    check("R9 idle cycles do not count", auxEnable, 1'b1);
    giveTicks(1);
    check("R9 last tick opens aux", auxEnable, 1'b0);
    fbBelowSkip = 1'b0; fbAboveExit = 1'b1;
    cyc(1);
    fbAboveExit = 1'b0;
  endtask

  task automatic testFault();
    check("R8 precondition aux closed", auxEnable, 1'b1);
    faultLatched = 1'b1;
    cyc(1);
    check("R8 fault opens aux", auxEnable, 1'b0);
    startupDone = 1'b0;
    cyc(3);
    faultLatched = 1'b0;
    cyc(4);
    check("R8 stays open until startup", auxEnable, 1'b0);
    startupDone = 1'b1;
    cyc(1);
    check("R8 reclosed after startup", auxEnable, 1'b1);
    fbBelowSkip = 1'b1;
    cyc(1);
    giveTicks(WIN);
    check("R8 standby before fault", auxEnable, 1'b0);
    faultLatched = 1'b1;
    fbBelowSkip = 1'b0; fbAboveExit = 1'b1;
    cyc(2);
    check("R8 fault blocks exit", auxEnable, 1'b0);
    faultLatched = 1'b0; fbAboveExit = 1'b0;
    cyc(2);
    check("R8 resumes with startup high", auxEnable, 1'b1);
  endtask

  initial begin
    cyc(1);
    testStartup();
    testEntry();
    testRipple();
    testExit();
    testRestart();
    testNoTick();
    testFault();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule